// File: doc/BRIEF.md
# Ultrasonic Ranging Measurement Controller

This block carries out one time-of-flight distance measurement for each single-cycle request it receives. First it raises the trigger line for a fixed number of clocks, about 10 µs. It then waits for the sensor's echo line to rise and counts the clocks for which echo stays high. When echo falls, it turns that count into whole centimetres. The conversion uses the speed of sound scaled to the clock frequency.

The result is written to a registered distance output, which holds its value until the next measurement ends. A one-cycle ready pulse marks each new value. If the echo never arrives, or stays high past the timeout window, the measurement ends with a saturated all-ones distance. The echo line comes from outside the clock domain, so it passes through a flop synchronizer before the sequencer uses it.

Top module: `ultrasonic_ranger`

## Requirements
- R1: During and after synchronous reset, `trig_o` and `rdy_o` are low and `dist_o` is zero.
- R2: A request on `start_i` while idle makes `trig_o` go high on the next clock edge. It then stays high for exactly `TRIG_CYC` cycles.
- R3: When the trigger phase ends, the controller waits for echo. Echo passes through `SYNC_STAGES` flops, 2 by default. With the default, `rdy_o` goes high at the third rising clock edge after `echo_i` falls.
- R4: The number of cycles for which echo was high (N) is reported as `dist_o` = floor(N × `SOUND_CM_S` / (2 × `CLK_HZ`)). Each measurement gives exactly one single-cycle `rdy_o` pulse.
- R5: `dist_o` changes only in the cycle where `rdy_o` is high. Between measurements it holds its value, even while echo toggles with no measurement running.
- R6: If echo does not rise within `TIMEOUT_CYC` cycles of the trigger ending, the measurement ends with `rdy_o` high and `dist_o` all ones.
- R7: An echo high for up to `TIMEOUT_CYC` cycles is converted normally. An echo high for longer ends the measurement early, while echo is still high, with `dist_o` all ones.
- R8: A request on `start_i` that arrives while a measurement is running has no effect. No new trigger is produced and the result is unchanged.
- R9: The echo count is cleared when each measurement starts, so each result depends only on its own echo.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Single-cycle measurement request |
| echo_i | input | 1 | Echo line from the sensor, asynchronous |
| trig_o | output | 1 | Trigger line to the sensor |
| dist_o | output | DIST_W | Last measured distance in centimetres, all ones when saturated |
| rdy_o | output | 1 | One-cycle pulse when a new distance is written |

## Verification
A sequencer stuck in the wrong state shows up at once on the trigger line or as a missing ready pulse. An early or late trigger exit appears as a pulse length other than `TRIG_CYC`, visible within one trigger window. A bad echo count or a count not cleared between runs shows up as a wrong distance at the next ready pulse. An off-by-one in the timeout is exposed by echo widths placed exactly at the limit and one past it. A behavioural model in the bench is compared with all three outputs on every cycle, so any divergence is reported in the cycle it first appears.

// File: rtl/ranger_pkg.sv
package ranger_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_TRIG  = 2'd1,
      ST_WAIT  = 2'd2,
      ST_COUNT = 2'd3
   } rng_state_t;
endpackage

// File: rtl/rng_sync.sv
module rng_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] pipe;

   if (STAGES < 2) begin : g_bad_stages
      $error("rng_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) begin
            pipe[i] <= 1'b0;
         end else if (i == 0) begin
            pipe[i] <= d_i;
         end else begin
            pipe[i] <= pipe[(i == 0) ? 0 : i-1];
         end
      end
   end

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/rng_fsm.sv
module rng_fsm
   import ranger_pkg::*;
#(
   parameter int TRIG_CYC    = 120,
   parameter int TIMEOUT_CYC = 360_000,
   parameter int RAW_W       = $clog2(TIMEOUT_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             echo_i,
   output logic             trig_o,
   output logic             done_o,
   output logic             sat_o,
   output logic [RAW_W-1:0] raw_o
);
   localparam int TC_W = $clog2(TRIG_CYC + 1);

   rng_state_t       state, nxt;
   logic [TC_W-1:0]  tcnt;
   logic [RAW_W-1:0] wcnt;
   logic [RAW_W-1:0] raw;

   always_comb begin
      nxt    = state;
      done_o = 1'b0;
      sat_o  = 1'b0;
      unique case (state)
         ST_IDLE:  if (start_i) nxt = ST_TRIG;
         ST_TRIG:  if (tcnt == TC_W'(TRIG_CYC - 1)) nxt = ST_WAIT;
         ST_WAIT: begin
            if (echo_i) begin
               nxt = ST_COUNT;
            end else if (wcnt == RAW_W'(TIMEOUT_CYC - 1)) begin
               nxt    = ST_IDLE;
               done_o = 1'b1;
               sat_o  = 1'b1;
            end
         end
         ST_COUNT: begin
            if (!echo_i) begin
               nxt    = ST_IDLE;
               done_o = 1'b1;
            end else if (raw == RAW_W'(TIMEOUT_CYC)) begin
               nxt    = ST_IDLE;
               done_o = 1'b1;
               sat_o  = 1'b1;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         tcnt  <= '0;
         wcnt  <= '0;
         raw   <= '0;
      end else begin
         state <= nxt;
         unique case (state)
            ST_IDLE: begin
               tcnt <= '0;
               wcnt <= '0;
               if (start_i) raw <= '0;
            end
            ST_TRIG:  tcnt <= tcnt + TC_W'(1);
            ST_WAIT: begin
               wcnt <= wcnt + RAW_W'(1);
               if (echo_i) raw <= RAW_W'(1);
            end
            ST_COUNT: if (echo_i && raw != RAW_W'(TIMEOUT_CYC)) raw <= raw + RAW_W'(1);
            default: ;
         endcase
      end
   end

   assign trig_o = (state == ST_TRIG);
   assign raw_o  = raw;

   AST_TRIG_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
      $rose(trig_o) |-> $past(start_i)); // R2
   AST_WAIT_TO_COUNT: assert property (@(posedge clk) disable iff (rst)
      (state == ST_WAIT && echo_i) |=> (state == ST_COUNT)); // R3
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      raw <= RAW_W'(TIMEOUT_CYC)); // R7
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
      (state == ST_WAIT || state == ST_COUNT) |=> !trig_o); // R8
endmodule

// File: rtl/rng_cvt.sv
module rng_cvt #(
   parameter int CLK_HZ      = 12_000_000,
   parameter int SOUND_CM_S  = 34_300,
   parameter int TIMEOUT_CYC = 360_000,
   parameter int RAW_W       = 19,
   parameter int DIST_W      = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              done_i,
   input  logic              sat_i,
   input  logic [RAW_W-1:0]  raw_i,
   output logic [DIST_W-1:0] dist_o,
   output logic              rdy_o
);
   localparam logic [63:0] DIVISOR = 64'(CLK_HZ) << 1;
   localparam logic [63:0] MAX_CM  = (64'(TIMEOUT_CYC) * 64'(SOUND_CM_S)) / DIVISOR;
   localparam logic [63:0] DMAX    = (64'd1 << DIST_W) - 64'd1;

   logic [63:0]       prod, quot;
   logic [DIST_W-1:0] cm;

   assign prod = 64'(raw_i) * 64'(SOUND_CM_S);
   assign quot = prod / DIVISOR;

   if (MAX_CM > DMAX) begin : g_clamp
      assign cm = (quot > DMAX) ? '1 : DIST_W'(quot);
   end else begin : g_direct
      assign cm = DIST_W'(quot);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dist_o <= '0;
         rdy_o  <= 1'b0;
      end else begin
         rdy_o <= done_i;
         if (done_i) dist_o <= sat_i ? '1 : cm;
      end
   end

   AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
      rdy_o |=> !rdy_o); // R4
   AST_HOLD: assert property (@(posedge clk) disable iff (rst)
      !rdy_o |-> $stable(dist_o)); // R5
   AST_SAT_MAX: assert property (@(posedge clk) disable iff (rst)
      (done_i && sat_i) |=> (rdy_o && dist_o == '1)); // R6
endmodule

// File: rtl/ultrasonic_ranger.sv
module ultrasonic_ranger #(
   parameter int CLK_HZ      = 12_000_000,
   parameter int SOUND_CM_S  = 34_300,
   parameter int TRIG_CYC    = 120,
   parameter int TIMEOUT_CYC = 360_000,
   parameter int DIST_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic              echo_i,
   output logic              trig_o,
   output logic [DIST_W-1:0] dist_o,
   output logic              rdy_o
);
   localparam int RAW_W = $clog2(TIMEOUT_CYC + 1);

   if (TRIG_CYC < 1)        begin : g_bad_trig    $error("TRIG_CYC must be positive"); end
   if (TIMEOUT_CYC < 2)     begin : g_bad_tmo     $error("TIMEOUT_CYC must be at least 2"); end
   if (DIST_W < 1)          begin : g_bad_dist    $error("DIST_W must be positive"); end
   if (CLK_HZ < 1)          begin : g_bad_clk     $error("CLK_HZ must be positive"); end
   if (RAW_W + 17 > 64)     begin : g_bad_prod    $error("product exceeds 64 bits"); end

   logic             echo_s;
   logic             done;
   logic             sat;
   logic [RAW_W-1:0] raw;

   rng_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (echo_i),
      .q_o (echo_s)
   );

   rng_fsm #(
      .TRIG_CYC    (TRIG_CYC),
      .TIMEOUT_CYC (TIMEOUT_CYC),
      .RAW_W       (RAW_W)
   ) u_fsm (
      .clk     (clk),
      .rst     (rst),
      .start_i (start_i),
      .echo_i  (echo_s),
      .trig_o  (trig_o),
      .done_o  (done),
      .sat_o   (sat),
      .raw_o   (raw)
   );

   rng_cvt #(
      .CLK_HZ      (CLK_HZ),
      .SOUND_CM_S  (SOUND_CM_S),
      .TIMEOUT_CYC (TIMEOUT_CYC),
      .RAW_W       (RAW_W),
      .DIST_W      (DIST_W)
   ) u_cvt (
      .clk    (clk),
      .rst    (rst),
      .done_i (done),
      .sat_i  (sat),
      .raw_i  (raw),
      .dist_o (dist_o),
      .rdy_o  (rdy_o)
   );
endmodule

// File: tb/sim_ultrasonic_ranger.sv
`timescale 1ns/1ps
module sim_ultrasonic_ranger;
   localparam int CLK_PERIOD = 10;
   localparam int TRIG = 120;
   localparam int TMO  = 9000;
   localparam int DW   = 16;
   localparam int DMAX = 65535;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start_i = 1'b0;
   logic echo_i = 1'b0;
   logic trig_o, rdy_o;
   logic [DW-1:0] dist_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit model_on = 0;

   // behavioural reference model state
   int  m_ph = 0;
   int  m_cnt = 0;
   longint m_raw = 0;
   bit  m_rdy = 0;
   int  m_dist = 0;
   bit  m_dly[$];

   ultrasonic_ranger #(.TRIG_CYC(TRIG), .TIMEOUT_CYC(TMO), .DIST_W(DW)) u0 (
      .clk(clk), .rst(rst), .start_i(start_i), .echo_i(echo_i),
      .trig_o(trig_o), .dist_o(dist_o), .rdy_o(rdy_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   always @(posedge clk) begin
      bit es;
      cycles++;
      model_on = 1;
      if (rst) begin
         m_ph = 0; m_cnt = 0; m_raw = 0; m_rdy = 0; m_dist = 0;
         m_dly = '{1'b0, 1'b0};
      end else begin
         es = m_dly[0];
         m_rdy = 0;
         case (m_ph)
            0: if (start_i) begin m_ph = 1; m_cnt = 0; m_raw = 0; end
            1: begin m_cnt++; if (m_cnt == TRIG) begin m_ph = 2; m_cnt = 0; end end
            2: if (es) begin m_ph = 3; m_raw = 1; end
               else begin
                  m_cnt++;
                  if (m_cnt == TMO) begin m_ph = 0; m_rdy = 1; m_dist = DMAX; end
               end
            default: if (!es) begin
                  m_ph = 0; m_rdy = 1; m_dist = int'((m_raw * 34300) / 24000000);
               end else if (m_raw == TMO) begin
                  m_ph = 0; m_rdy = 1; m_dist = DMAX;
               end else m_raw++;
         endcase
         void'(m_dly.pop_front());
         m_dly.push_back(echo_i);
      end
   end

   always @(negedge clk) begin
      if (model_on) begin
         chk("R2", "trig vs model", trig_o, (m_ph == 1));
         chk("R4", "rdy vs model", rdy_o, m_rdy);
         chk("R5", "dist vs model", dist_o, m_dist);
      end
   end

   task automatic measure(input string req, input int width, input int exp, input bit busy_req);
      int tc = 0;
      int pulses = 0;
      int vidx = -1;
      int got = -1;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      for (int i = 0; i < 200; i++) begin
         if (trig_o) tc++;
         @(negedge clk);
      end
      chk("R2", "trigger length", tc, TRIG);
      if (width > 0) begin
         echo_i = 1'b1;
         for (int i = 0; i < width; i++) begin
            start_i = (busy_req && i == width/2);
            @(negedge clk);
            if (rdy_o) begin pulses++; got = dist_o; end
         end
         start_i = 1'b0;
         echo_i = 1'b0;
         for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (rdy_o) begin pulses++; got = dist_o; vidx = i; end
            if (busy_req) chk("R8", "no trigger after busy request", trig_o, 0);
         end
         if (width <= TMO) chk("R3", "ready latency after echo fall", vidx, 3);
      end else begin
         for (int i = 0; i < TMO + 50; i++) begin
            @(negedge clk);
            if (rdy_o) begin pulses++; got = dist_o; end
         end
      end
      chk(req, "distance", got, exp);
      chk("R4", "ready pulse count", pulses, 1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk("R1", "trig in reset", trig_o, 0);
      chk("R1", "rdy in reset", rdy_o, 0);
      chk("R1", "dist in reset", dist_o, 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "dist after reset", dist_o, 0);
      measure("R4", 7000, 10, 1'b0);
      measure("R8", 3500, 5, 1'b1);
      measure("R4", 1, 0, 1'b0);
      measure("R7", TMO, 12, 1'b0);
      measure("R7", TMO + 1, DMAX, 1'b0);
      measure("R6", 0, DMAX, 1'b0);
      measure("R9", 700, 1, 1'b0);
      // echo activity with nothing running must not touch the result
      for (int i = 0; i < 40; i++) begin
         echo_i = i[2];
         @(negedge clk);
         chk("R5", "idle echo: no ready", rdy_o, 0);
         chk("R5", "idle echo: distance held", dist_o, 1);
      end
      echo_i = 1'b0;
      repeat (10) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      while (cycles < 150_000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule